// File: doc/BRIEF.md
# SIMD Compare, Min/Max and Average Unit

This block performs one lane-parallel operation per accepted request on two 64-bit operands. A size input divides each operand into eight byte lanes, four halfword lanes or two word lanes, and every lane is computed without reference to its neighbours. The unit supports these operation groups:

- equality and greater-than compares, producing a mask per lane;
- signed and unsigned minimum and maximum;
- add and subtract that wrap within each lane;
- averaging of byte and halfword lanes, with an optional rounding increment.

The unit also builds a 32-bit status word from the result. For each lane it holds a negative flag and a zero flag, and the position of those flags depends on the lane size. The result, the status word and an output valid are all registered. A request is accepted in any cycle where the input valid is high.

Top module: `simd_lane_unit`

## Requirements
- R1: After reset, valid_o is 0, result_o is 0 and status_o is 0.
- R2: At a clock edge where valid_i is 1, result_o and status_o load the new values and valid_o becomes 1. At an edge where valid_i is 0, valid_o becomes 0 and result_o and status_o keep their values.
- R3: Compares write all ones into a lane when the relation holds and all zeros when it does not. The op_i codes are 0 for equality, 1 for signed a>b (two's complement) and 2 for unsigned a>b.
- R4: Min and max copy the whole lane from a or from b. The op_i codes are 3 for signed min, 4 for unsigned min, 5 for signed max and 6 for unsigned max.
- R5: Add (op_i=7) and subtract a-b (op_i=8) wrap modulo the lane width, and no carry passes between lanes.
- R6: Average (op_i=9) gives each lane (a+b+round_i)>>1, computed without overflow. It is defined for byte and halfword lanes. With word lanes it yields a result of 0 and a status of 0.
- R7: The size_i codes are 0 for byte lanes, 1 for halfword lanes and 2 for word lanes. size_i=3 yields a result of 0 and a status of 0.
- R8: Lane i of width W has its negative flag at status bit (W/2)*i+W/2-1 and its zero flag at bit (W/2)*i+W/2-2. The negative flag is the top bit of the result lane. The zero flag is 1 when the result lane is all zeros.
- R9: For average, every negative flag is 0 and only the zero flags are set.
- R10: Every status bit other than the negative and zero flags is always 0. These are the carry and overflow slots, and for bytes they are bits 4i+1 and 4i.
- R11: op_i codes 10 to 15 yield a result of 0 and a status of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Lane size code |
| round_i | input | 1 | Rounding increment for average |
| a_i | input | 64 | Operand a |
| b_i | input | 64 | Operand b |
| valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Lane results |
| status_o | output | 32 | Packed negative and zero flags per lane |

## Verification
The bench builds the block with its default parameters: a 64-bit data path and a 32-bit status word. With these defaults all three lane sizes are real, and the three flag strides (4, 8 and 16 bits) are all in use. That makes it possible to check the flag placement and the lane boundaries for carries against an independent per-lane model. Directed cases cover the following:

- the 0x80 versus 0x7F split between the signed and unsigned relations;
- average overflow at all ones;
- add wrapping to zero, so that the zero flag is set;
- the undefined size, the undefined operation codes and word-lane average.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
  typedef enum logic [3:0] {
    OP_EQ   = 4'd0,
    OP_GTS  = 4'd1,
    OP_GTU  = 4'd2,
    OP_MINS = 4'd3,
    OP_MINU = 4'd4,
    OP_MAXS = 4'd5,
    OP_MAXU = 4'd6,
    OP_ADD  = 4'd7,
    OP_SUB  = 4'd8,
    OP_AVG  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_lane_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  op_e               op_i,
  input  logic              round_i,
  output logic [LANE_W-1:0] res_o
);
  logic              s_gt, u_gt, eq;
  logic [LANE_W:0]   avg_sum;

  assign s_gt    = $signed(a_i) > $signed(b_i);
  assign u_gt    = a_i > b_i;
  assign eq      = a_i == b_i;
  // one extra bit so the average cannot overflow
  assign avg_sum = {1'b0, a_i} + {1'b0, b_i} + {{LANE_W{1'b0}}, round_i};

  always_comb begin
    case (op_i)
      OP_EQ:   res_o = {LANE_W{eq}};
      OP_GTS:  res_o = {LANE_W{s_gt}};
      OP_GTU:  res_o = {LANE_W{u_gt}};
      OP_MINS: res_o = (s_gt || eq) ? b_i : a_i;
      OP_MINU: res_o = (u_gt || eq) ? b_i : a_i;
      OP_MAXS: res_o = s_gt ? a_i : b_i;
      OP_MAXU: res_o = u_gt ? a_i : b_i;
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AVG:  res_o = avg_sum[LANE_W:1];
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_flags.sv
module simd_lane_flags #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned STAT_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              zero_only_i,
  output logic [STAT_W-1:0] stat_o
);
  localparam int unsigned NUM_LANES = DATA_W / LANE_W;
  localparam int unsigned STRIDE    = STAT_W / NUM_LANES;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign stat_o[STRIDE*i+STRIDE-1] = ~zero_only_i & res_i[LANE_W*i+LANE_W-1];
    assign stat_o[STRIDE*i+STRIDE-2] = res_i[LANE_W*i +: LANE_W] == '0;
    // carry/overflow slots are never produced
    for (genvar k = 0; k < STRIDE - 2; k++) begin : g_pad
      assign stat_o[STRIDE*i+k] = 1'b0;
    end
  end
endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              round_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [STAT_W-1:0] status_o
);
  op_e               op;
  logic              is_avg;
  logic              req_ok;
  logic [DATA_W-1:0] res_sz  [NUM_SIZES];
  logic [STAT_W-1:0] stat_sz [NUM_SIZES];
  logic [DATA_W-1:0] res_d;
  logic [STAT_W-1:0] stat_d;

  assign op     = op_e'(op_i);
  assign is_avg = op_i == OP_AVG;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned LW = 8 << g;
    localparam int unsigned NL = DATA_W / LW;
    logic [DATA_W-1:0] res_g;
    logic [STAT_W-1:0] stat_g;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      simd_lane_alu #(.LANE_W(LW)) i_alu (
        .a_i    (a_i[LW*l +: LW]),
        .b_i    (b_i[LW*l +: LW]),
        .op_i   (op),
        .round_i(round_i),
        .res_o  (res_g[LW*l +: LW])
      );
    end

    simd_lane_flags #(.LANE_W(LW), .DATA_W(DATA_W), .STAT_W(STAT_W)) i_flags (
      .res_i      (res_g),
      .zero_only_i(is_avg),
      .stat_o     (stat_g)
    );

    assign res_sz[g]  = res_g;
    assign stat_sz[g] = stat_g;
  end

  // undefined size, undefined op, or word-lane average: zero out
  assign req_ok = (size_i != 2'd3) && (op_i <= OP_AVG) &&
                  !(is_avg && size_i == SZ_WORD);

  always_comb begin
    res_d  = '0;
    stat_d = '0;
    if (req_ok) begin
      res_d  = res_sz[size_i];
      stat_d = stat_sz[size_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      status_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        status_o <= stat_d;
      end
    end
  end
endmodule

// File: rtl/simd_lane_unit_chk.sv
module simd_lane_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [1:0]        size_i,
  input logic              round_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [STAT_W-1:0] status_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(status_o)));

  a_r3_equal_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd0 && size_i != 2'd3 && a_i == b_i) |=> (&result_o));

  a_r10_byte_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd0) |=> ((status_o & 32'h3333_3333) == 32'h0));

  a_r10_half_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd1) |=> ((status_o & 32'h3F3F_3F3F) == 32'h0));

  a_r9_avg_no_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd9 && size_i == 2'd0) |=> ((status_o & 32'h8888_8888) == 32'h0));

  a_r8_word_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd2 && op_i <= 4'd8) |=>
      (status_o[14] == (result_o[31:0] == 32'h0) && status_o[15] == result_o[31]));

  a_r11_bad_op_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd9) |=> (result_o == '0 && status_o == '0));
endmodule

bind simd_lane_unit simd_lane_unit_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
  .round_i(round_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o),
  .result_o(result_o), .status_o(status_o)
);

// File: tb/test_simd_lane_unit.sv
module test_simd_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        round_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [31:0] status_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] exp_res = '0;
  logic [31:0] exp_stat = '0;

  always #2 clk = ~clk;

  simd_lane_unit i_simd_lane_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .round_i(round_i), .a_i(a_i), .b_i(b_i), .valid_o(valid_o),
    .result_o(result_o), .status_o(status_o)
  );

  function automatic logic [95:0] model(input logic [3:0] op, input logic [1:0] sz,
                                        input logic rnd, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    logic [31:0] s = '0;
    int w, nl, st;
    if (sz == 2'd3 || op > 4'd9 || (op == 4'd9 && sz == 2'd2)) return '0;
    w = 8 << sz; nl = 64 / w; st = 32 / nl;
    for (int l = 0; l < nl; l++) begin
      longint m, la, lb, sa, sb, rl;
      m  = (longint'(1) << w) - 1;
      la = longint'((a >> (l*w))) & m;
      lb = longint'((b >> (l*w))) & m;
      sa = la[w-1] ? la - (longint'(1) << w) : la;
      sb = lb[w-1] ? lb - (longint'(1) << w) : lb;
      case (op)
        4'd0: rl = (la == lb) ? m : 0;
        4'd1: rl = (sa > sb) ? m : 0;
        4'd2: rl = (la > lb) ? m : 0;
        4'd3: rl = (sa < sb) ? la : lb;
        4'd4: rl = (la < lb) ? la : lb;
        4'd5: rl = (sa > sb) ? la : lb;
        4'd6: rl = (la > lb) ? la : lb;
        4'd7: rl = (la + lb) & m;
        4'd8: rl = (la - lb) & m;
        default: rl = (la + lb + longint'(rnd)) >> 1;
      endcase
      r = r | (64'(rl) << (l*w));
      if (op != 4'd9) s[st*l+st-1] = rl[w-1];
      s[st*l+st-2] = (rl == 0);
    end
    return {s, r};
  endfunction

  task automatic step(input logic v, input logic [3:0] op, input logic [1:0] sz,
                      input logic rnd, input logic [63:0] a, input logic [63:0] b,
                      input string tag);
    logic [95:0] m;
    valid_i = v; op_i = op; size_i = sz; round_i = rnd; a_i = a; b_i = b;
    m = model(op, sz, rnd, a, b);
    @(posedge clk);
    if (v) begin exp_res = m[63:0]; exp_stat = m[95:64]; end
    @(negedge clk);
    checks++;
    if (valid_o !== v) begin
      errors++; $display("FAIL %s valid_o act=%0b exp=%0b", tag, valid_o, v);
    end
    checks++;
    if (result_o !== exp_res) begin
      errors++; $display("FAIL %s result act=%h exp=%h", tag, result_o, exp_res);
    end
    checks++;
    if (status_o !== exp_stat) begin
      errors++; $display("FAIL %s status act=%h exp=%h", tag, status_o, exp_stat);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0 || status_o !== '0) begin
      errors++; $display("FAIL R1 act=%b/%h/%h exp=0/0/0", valid_o, result_o, status_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 4'd0, 2'd0, 0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, "R3 eq byte");
    step(1, 4'd1, 2'd0, 0, 64'h80_7F_80_7F_00_FF_01_FF, 64'h7F_80_7F_80_FF_00_FF_01, "R3 gts byte");
    step(1, 4'd2, 2'd0, 0, 64'h80_7F_80_7F_00_FF_01_FF, 64'h7F_80_7F_80_FF_00_FF_01, "R3 gtu byte");
    step(1, 4'd1, 2'd2, 0, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, "R3 gts word");
    step(1, 4'd3, 2'd1, 0, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0001, "R4 mins half");
    step(1, 4'd6, 2'd1, 0, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0001, "R4 maxu half");
    step(1, 4'd7, 2'd0, 0, 64'hFF01_FF01_FF01_FF01, 64'h01FF_01FF_0100_0000, "R5 add wrap byte");
    step(1, 4'd8, 2'd2, 0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0000, "R5 sub wrap word");
    step(1, 4'd9, 2'd0, 1, 64'hFF_FF_01_01_00_00_FE_80, 64'hFF_FE_00_00_00_01_FF_80, "R6 R9 avg round byte");
    step(1, 4'd9, 2'd1, 0, 64'hFFFF_0001_0000_8000, 64'hFFFF_0000_0000_8000, "R6 R9 avg half");
    step(1, 4'd9, 2'd2, 1, 64'h1234_5678_9ABC_DEF0, 64'h1, "R6 avg word zero");
    step(1, 4'd7, 2'd3, 0, 64'h1234_5678_9ABC_DEF0, 64'h1, "R7 size3 zero");
    step(1, 4'd12, 2'd0, 0, 64'h1234_5678_9ABC_DEF0, 64'h1, "R11 bad op");
    step(1, 4'd0, 2'd1, 0, 64'h0, 64'h0001_0000_0000_0000, "R8 R10 half flags");
    step(0, 4'd7, 2'd0, 0, 64'hDEAD_BEEF_0000_1111, 64'h5, "R2 hold");
    step(1, 4'd5, 2'd2, 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_8000_0000, "R2 R4 maxs word");

    for (int n = 0; n < 600; n++) begin
      logic [63:0] a, b;
      logic [3:0] op;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b = a;
      op = 4'($urandom_range(0, 10));
      step($urandom_range(0, 3) != 0, op, 2'($urandom_range(0, 3)), 1'($urandom),
           a, b, "random R3..R11");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule